// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Sequencer

This block produces the pin-level control for a single memory or I/O transfer of a 16-bit processor bus with a 20-bit address. The processor is running in its simple single-master mode. A one-cycle start request carries these fields:

- the transfer address
- whether it is a write
- whether it targets I/O space
- whether the upper data byte is needed
- a two-bit segment tag
- the write data

The sequencer walks through four bus clock states. Between the third and the last it inserts extra wait cycles for as long as the responding device holds its ready line low.

The low sixteen bus lines are time-shared between address and data. The four upper lines carry address first and a status code afterwards. The block drives an address strobe, separate read and write strobes, a space select, a transceiver direction line, a transceiver enable and a high-byte enable. On a read, the value on the bus is captured in the cycle where ready is seen high. It is then handed back with a one-cycle completion pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and whenever idle: `ale`=0, `rd_n`=1, `wr_n`=1, `den_n`=1, `bhe_n`=1, `done`=0, `busy`=0, `ad_oe`=0, `io_m`=0, `dt_r`=1.
- R2: `req_go` starts a transfer only while `busy` is 0, and the first state (T1) follows in the next cycle. A `req_go` seen while `busy` is 1 is ignored and produces no further address strobe.
- R3: `ale` is high for exactly one cycle per transfer, in T1. In that cycle `ad_out` equals address bits 15..0 with `ad_oe`=1, and `as_out` equals address bits 19..16.
- R4: From T2 to the end of the transfer, `as_out` = {0, 0, seg[1], seg[0]}. Bit 1 (A17/S4) and bit 0 (A16/S3) carry the segment tag, coded 00 extra, 01 stack, 10 code, 11 data.
- R5: `bhe_n` is low in T1 exactly when `req_hi` was set, and high in every other cycle.
- R6: For the whole transfer, `io_m` is 1 for I/O and 0 for memory. For the whole transfer, `dt_r` is 1 for a write and 0 for a read.
- R7: For a read, `rd_n` is low from T2 through the last wait state, and for a write `wr_n` is low over the same span. The two are never low together.
- R8: `rdy_in` is sampled at the end of T3 and at the end of every wait state. Each low sample adds one wait state, so the strobe lasts 2 + (number of low samples) cycles.
- R9: `den_n` is low in exactly the cycles where a strobe is low, and high in T1 and T4.
- R10: On a write, `ad_out` carries the write data with `ad_oe`=1 from T2 through T4. On a read, `ad_oe` is 0 after T1.
- R11: On a read, `rdata` holds the `ad_in` value from the cycle in which `rdy_in` was sampled high. `done` pulses for one cycle in T4, and `busy` falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | 1 | Start pulse for one transfer |
| req_addr | input | 20 | Transfer address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_hi | input | 1 | Upper data byte is used |
| req_seg | input | 2 | Segment tag for the status code |
| req_wdata | input | 16 | Write data |
| rdy_in | input | 1 | Device ready, low to stretch |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| as_out | output | 4 | Upper address / status lines |
| ale | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Space select, 1 = I/O |
| dt_r | output | 1 | Transceiver direction, 1 = outbound |
| den_n | output | 1 | Transceiver enable, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| rdata | output | 16 | Captured read data |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Two things can happen in the same cycle:

- **READY rising while read data is captured.** The cycle in which ready is sampled high is also the cycle in which read data must be latched. The bench holds a deliberately wrong value on `ad_in` while ready is low, and switches to the real value on the same edge that raises ready. The completion cycle must show the real value, with a strobe length that matches the wait count.
- **A new start arriving mid-transfer.** A fresh start pulse with a different address is placed in the middle of a transfer. The monitor flags any address strobe that has no queued expectation, and the queue must be empty at the end.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_wr,
  input  logic             req_io,
  input  logic             req_hi,
  input  logic [1:0]       req_seg,
  input  logic [DW-1:0]    req_wdata,
  input  logic             rdy_in,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic             dt_r,
  output logic             den_n,
  output logic             bhe_n,
  output logic [DW-1:0]    rdata,
  output logic             done,
  output logic             busy
);
  localparam int UW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    seg_q;
  logic          wr_q, io_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      seg_q   <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      hi_q    <= 1'b0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_go) begin
          st      <= S_T1;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          seg_q   <= req_seg;
          wr_q    <= req_wr;
          io_q    <= req_io;
          hi_q    <= req_hi;
        end
        S_T1: st <= S_T2;
        S_T2: st <= S_T3;
        S_T3, S_TW: begin
          if (rdy_in) begin
            st <= S_T4;
            if (!wr_q) rdata <= ad_in;
          end else begin
            st <= S_TW;
          end
        end
        S_T4: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_t1, strobe;
  assign in_t1  = (st == S_T1);
  assign strobe = (st == S_T2) || (st == S_T3) || (st == S_TW);

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_T4);
  assign ale    = in_t1;
  assign rd_n   = !(strobe && !wr_q);
  assign wr_n   = !(strobe && wr_q);
  assign den_n  = !strobe;
  assign io_m   = busy && io_q;
  assign dt_r   = busy ? wr_q : 1'b1;
  assign bhe_n  = !(in_t1 && hi_q);
  assign ad_oe  = in_t1 || (busy && wr_q);
  assign ad_out = in_t1 ? addr_q[DW-1:0] : ((busy && wr_q) ? wdata_q : '0);

  always_comb begin
    as_out = '0;
    if (in_t1)     as_out = addr_q[AW-1:DW];
    else if (busy) as_out = {{(UW-2){1'b0}}, seg_q};
  end

  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r3_strobe_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T3 || st == S_TW) && !rdy_in) |=> (!rd_n || !wr_n));
  a_r9_den_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !den_n);
  a_r11_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rdy_in));
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !ale);
endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  logic clk = 0, rst_n = 0;
  logic req_go = 0, req_wr = 0, req_io = 0, req_hi = 0, rdy_in = 1;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic [15:0] ad_out, rdata;
  logic [3:0]  as_out;
  logic ad_oe, ale, rd_n, wr_n, io_m, dt_r, den_n, bhe_n, done, busy;

  always #2.5 clk = ~clk;

  bus_cycle_seq u0 (.*);

  typedef struct {
    logic [19:0] addr; logic wr, io, hi; logic [1:0] seg;
    logic [15:0] wdata; int waits; logic [15:0] rval;
  } item_t;
  item_t exq[$];

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic issue(input logic [19:0] a, input logic w, input logic io,
                       input logic hi, input logic [1:0] sg, input logic [15:0] wd,
                       input int waits, input logic [15:0] rv, input bit poke);
    item_t it;
    it.addr = a; it.wr = w; it.io = io; it.hi = hi; it.seg = sg;
    it.wdata = wd; it.waits = waits; it.rval = rv;
    exq.push_back(it);
    @(negedge clk);
    req_go = 1; req_addr = a; req_wr = w; req_io = io; req_hi = hi;
    req_seg = sg; req_wdata = wd;
    @(negedge clk);
    req_go = 0; req_addr = 20'h0; req_wdata = 16'h0;
    @(negedge clk);
    if (poke) begin req_go = 1; req_addr = 20'hBAD00; end
    rdy_in = (waits == 0);
    ad_in  = (waits == 0) ? rv : ~rv;
    if (waits > 0) begin
      repeat (waits + 1) @(negedge clk);
      req_go = 0;
      rdy_in = 1; ad_in = rv;
    end else begin
      @(negedge clk);
      req_go = 0;
    end
    while (busy) @(negedge clk);
    ad_in = 16'h5A5A;
  endtask

  initial begin : monitor
    item_t it;
    int scyc;
    forever begin
      @(negedge clk);
      if (rst_n && ale) begin
        if (exq.size() == 0) begin
          chk(0, "R2 unexpected ale", 1, 0);
        end else begin
          it = exq.pop_front();
          chk(ad_out == it.addr[15:0] && ad_oe, "R3 T1 low address", ad_out, it.addr[15:0]);
          chk(as_out == it.addr[19:16], "R3 T1 upper address", as_out, it.addr[19:16]);
          chk(bhe_n == !it.hi, "R5 T1 bhe_n", bhe_n, !it.hi);
          chk(io_m == it.io && dt_r == it.wr, "R6 T1 io_m/dt_r", {io_m, dt_r}, {it.io, it.wr});
          chk(den_n && rd_n && wr_n, "R9 T1 den/strobes idle", {den_n, rd_n, wr_n}, 7);
          scyc = 0;
          @(negedge clk);
          while ((!rd_n || !wr_n) && scyc < 100) begin
            scyc++;
            chk(!ale, "R3 ale single", ale, 0);
            chk(rd_n == it.wr && wr_n == !it.wr, "R7 strobe select", {rd_n, wr_n}, {it.wr, !it.wr});
            chk(as_out == {2'b00, it.seg}, "R4 status code", as_out, {2'b00, it.seg});
            chk(!den_n, "R9 den low with strobe", den_n, 0);
            chk(bhe_n, "R5 bhe high after T1", bhe_n, 1);
            chk(io_m == it.io && dt_r == it.wr, "R6 held io_m/dt_r", {io_m, dt_r}, {it.io, it.wr});
            if (it.wr) chk(ad_oe && ad_out == it.wdata, "R10 write data", ad_out, it.wdata);
            else       chk(!ad_oe, "R10 read no drive", ad_oe, 0);
            @(negedge clk);
          end
          chk(scyc == 2 + it.waits, "R8 strobe length", scyc, 2 + it.waits);
          chk(done && busy && den_n, "R11 done in T4", {done, busy, den_n}, 7);
          chk(as_out == {2'b00, it.seg}, "R4 status in T4", as_out, {2'b00, it.seg});
          if (it.wr) chk(ad_oe && ad_out == it.wdata, "R10 write data T4", ad_out, it.wdata);
          else       chk(rdata == it.rval, "R11 read capture", rdata, it.rval);
          @(negedge clk);
          chk(!done && !busy, "R11 busy falls", {done, busy}, 0);
          chk(!io_m && dt_r && !ad_oe, "R1 idle after cycle", {io_m, dt_r, ad_oe}, 2);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && den_n && bhe_n && !done && !busy && !ad_oe,
        "R1 reset state", {ale, rd_n, wr_n, den_n, bhe_n, done, busy, ad_oe}, 8'b01111000);
    chk(!io_m && dt_r, "R1 reset io_m/dt_r", {io_m, dt_r}, 1);
    rst_n = 1;
    @(negedge clk);
    issue(20'hA1234, 0, 0, 1, 2'b11, 16'h0, 0, 16'hBEEF, 0);
    issue(20'h0F00E, 1, 1, 0, 2'b00, 16'hC0DE, 2, 16'h0, 0);
    issue(20'h3FF01, 0, 1, 1, 2'b01, 16'h0, 3, 16'h1357, 0);
    issue(20'hFFFFF, 1, 0, 1, 2'b10, 16'h8001, 0, 16'h0, 0);
    issue(20'h54321, 0, 0, 0, 2'b11, 16'h0, 1, 16'h2468, 1);
    issue(20'h00000, 1, 0, 0, 2'b00, 16'hFFFF, 1, 16'h0, 1);
    for (int i = 0; i < 6; i++)
      issue(20'h10000 * i + 20'h0111 * i, i[0], i[1], i[2], i[1:0],
            16'h1111 * i, i % 4, 16'hF0F0 ^ i[15:0], 0);
    repeat (4) @(negedge clk);
    chk(exq.size() == 0, "R2 all transfers seen", exq.size(), 0);
    chk(!ale && !busy, "R1 final idle", {ale, busy}, 0);
    finish_run();
  end
endmodule